// File: doc/BRIEF.md
# Two-Tier Maskable Interrupt Controller

This block gathers the interrupt events of a small 8-bit processor into one request line. Three core sources (an external pin edge, a port-change event and a timer-0 overflow) are gated only by their own enable bits. Up to fourteen peripheral sources must also pass a shared peripheral group enable. A global enable sits above both tiers. Every event latches a flag bit whatever the masks say. Software clears a flag by writing it through a byte-wide register bus.

The CPU sees a registered request, a fixed vector address and a wake-up line. The wake-up line follows the masked flags even while the global enable is clear, so a sleeping core can resume without taking the interrupt. When the CPU takes the interrupt it pulses `irq_ack`, and the controller clears the global enable. A `irq_ret` pulse sets the global enable again. If a flag is still set at that point, the request comes back at once.

Each raw event passes through two synchronizing flops and a rising-edge detector. A level that stays high therefore sets its flag only once.

Top module: `irq_two_tier`

## Requirements
- R1: A rising edge on any `core_evt` or `periph_evt` bit sets that source's flag, whatever the state of its enable, the group enable or the global enable. An input held high sets its flag only once: if the flag is cleared while the input stays high, the flag stays clear.
- R2: A flag stays set until software writes a 0 to it. If a new event arrives in the same cycle as that write, the event wins and the flag stays set.
- R3: A core source raises `irq_req` only when its own enable and the global enable are both set.
- R4: A peripheral source raises `irq_req` only when its own enable, the group enable and the global enable are all set.
- R5: While the global enable is clear, `irq_req` stays low. An enabled flag that is set stays pending, and it raises `irq_req` one cycle after the global enable is set.
- R6: A cycle with `irq_ack` high clears the global enable at the next edge, and `irq_req` is low after that edge.
- R7: A cycle with `irq_ret` high (and `irq_ack` low) sets the global enable. If an enabled flag is still set, `irq_req` rises one cycle later. If no such flag is set, `irq_req` stays low.
- R8: `wake` is high whenever a core flag and its enable are both set, or a peripheral flag, its enable and the group enable are all set. The global enable has no effect on it.
- R9: After reset, every register reads 0 (the global enable is clear) and `irq_req` and `wake` are low.
- R10: `vec_addr` always reads 0x0004.
- R11: For an event input that rises between edges, the flag reads set after the third rising clock edge and `irq_req` rises after the fourth, provided the source is fully enabled.
- R12: Register map, by `bus_addr`:
  - Address 0 holds the control byte: bit 7 is the global enable, bit 6 the group enable, bits 5..3 the core enables (bit 3 pin, bit 4 port-change, bit 5 timer-0), and bits 2..0 the core flags (bit 0 pin, bit 1 port-change, bit 2 timer-0).
  - Addresses 1 and 2 hold peripheral flags 7..0 and 13..8.
  - Addresses 3 and 4 hold peripheral enables 7..0 and 13..8.
  - Bits with no source behind them read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_evt | input | 3 | Raw core events: bit 0 pin, bit 1 port-change, bit 2 timer-0 |
| periph_evt | input | NP (14) | Raw peripheral events |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW (3) | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_req | output | 1 | Registered interrupt request to the CPU |
| irq_ack | input | 1 | CPU is entering the service routine |
| irq_ret | input | 1 | CPU is returning from the service routine |
| vec_addr | output | VW (13) | Fixed service entry address |
| wake | output | 1 | Wake-up from sleep |

## Verification
The embedded properties check the following on every cycle:
- each detected edge has set its flag;
- flags never drop without a bus write;
- a request is preceded by a set global enable;
- a peripheral-only request implies the group enable;
- the enter and return pulses move the global enable.

Only the bench scenarios can show the following:
- the exact 3/4-edge latency;
- the single flag set from a held level;
- the event-beats-clear race;
- a pending request surviving a period with the global enable clear;
- the request coming back after return when a flag was left set;
- the contents of the register map.

// File: rtl/irq_two_tier.sv
module irq_two_tier #(
  parameter int NP = 14,
  parameter int AW = 3,
  parameter int VW = 13,
  parameter logic [VW-1:0] VEC = 13'h0004
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    core_evt,
  input  logic [NP-1:0] periph_evt,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          irq_req,
  input  logic          irq_ack,
  input  logic          irq_ret,
  output logic [VW-1:0] vec_addr,
  output logic          wake
);

  localparam int NS = NP + 3;
  localparam int PB = (NP + 7) / 8;
  localparam int PW = PB * 8;
  localparam logic [AW-1:0] A_CTRL = '0;

  // two-flop synchronizer plus edge detector
  logic [NS-1:0] s1, s2, s3, hit;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= {periph_evt, core_evt};
      s2 <= s1;
      s3 <= s2;
    end
  assign hit = s2 & ~s3;

  logic          gie, peie;
  logic [2:0]    cen, cfl;
  logic [NP-1:0] pen, pfl;
  logic          wr_ctrl;
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gie  <= 1'b0;
      peie <= 1'b0;
      cen  <= '0;
      cfl  <= '0;
    end else begin
      if (irq_ack)      gie <= 1'b0;
      else if (irq_ret) gie <= 1'b1;
      else if (wr_ctrl) gie <= bus_wdata[7];
      if (wr_ctrl) begin
        peie <= bus_wdata[6];
        cen  <= bus_wdata[5:3];
        cfl  <= bus_wdata[2:0] | hit[2:0];
      end else begin
        cfl  <= cfl | hit[2:0];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pfl <= '0;
      pen <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (bus_wr && bus_addr == AW'(1 + i / 8))
          pfl[i] <= bus_wdata[i % 8] | hit[3 + i];
        else
          pfl[i] <= pfl[i] | hit[3 + i];
        if (bus_wr && bus_addr == AW'(1 + PB + i / 8))
          pen[i] <= bus_wdata[i % 8];
      end
    end

  logic core_hot, periph_hot;
  assign core_hot   = |(cfl & cen);
  assign periph_hot = peie & |(pfl & pen);
  assign wake       = core_hot | periph_hot;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_req <= 1'b0;
    else        irq_req <= gie & wake & ~irq_ack;

  assign vec_addr = VEC;

  logic [PW-1:0] pfl_pad, pen_pad;
  assign pfl_pad = PW'(pfl);
  assign pen_pad = PW'(pen);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata = {gie, peie, cen, cfl};
    for (int b = 0; b < PB; b++) begin
      if (bus_addr == AW'(1 + b))      bus_rdata = pfl_pad[b*8 +: 8];
      if (bus_addr == AW'(1 + PB + b)) bus_rdata = pen_pad[b*8 +: 8];
    end
  end

  logic [NS-1:0] flags_all;
  assign flags_all = {pfl, cfl};

  a_r1_flag_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((flags_all & $past(hit)) == $past(hit)));

  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ((flags_all & $past(flags_all)) == $past(flags_all)));

  a_r4_group_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !$past(core_hot)) |-> $past(peie));

  a_r5_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(gie));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!gie && !irq_req));

  a_r7_ret_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack) |=> gie);

endmodule

// File: tb/tb_irq_two_tier.sv
module tb_irq_two_tier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  core_evt = '0;
  logic [13:0] periph_evt = '0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_req;
  logic        irq_ack = 1'b0;
  logic        irq_ret = 1'b0;
  logic [12:0] vec_addr;
  logic        wake;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_two_tier dut (
    .clk(clk), .rst_n(rst_n), .core_evt(core_evt), .periph_evt(periph_evt),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .vec_addr(vec_addr), .wake(wake));

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] pen;
    logic [2:0]  cev;
    logic [13:0] pev;
    logic        req;
    logic        wk;
  } vec_t;

  localparam vec_t TAB [9] = '{
    '{8'h88, 16'h0000, 3'b001, 14'h0000, 1'b1, 1'b1},
    '{8'h08, 16'h0000, 3'b001, 14'h0000, 1'b0, 1'b1},
    '{8'h90, 16'h0000, 3'b001, 14'h0000, 1'b0, 1'b0},
    '{8'hC0, 16'h0001, 3'b000, 14'h0001, 1'b1, 1'b1},
    '{8'h80, 16'h0001, 3'b000, 14'h0001, 1'b0, 1'b0},
    '{8'hC0, 16'h2000, 3'b000, 14'h2000, 1'b1, 1'b1},
    '{8'hC0, 16'h0020, 3'b000, 14'h0040, 1'b0, 1'b0},
    '{8'h20, 16'h0000, 3'b100, 14'h0000, 1'b0, 1'b1},
    '{8'h40, 16'h0100, 3'b000, 14'h0100, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R9 / R10 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R9 reg after reset", 16'(d), 16'h0);
    end
    chk("R9 irq_req after reset", 16'(irq_req), 16'h0);
    chk("R9 wake after reset", 16'(wake), 16'h0);
    chk("R10 vector", 16'(vec_addr), 16'h0004);

    // table: R1 R3 R4 R8
    for (int k = 0; k < 9; k++) begin
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h00);
      wr(3'd2, 8'h00);
      wr(3'd3, TAB[k].pen[7:0]);
      wr(3'd4, TAB[k].pen[15:8]);
      wr(3'd0, TAB[k].ctrl);
      core_evt = TAB[k].cev;
      periph_evt = TAB[k].pev;
      @(negedge clk);
      core_evt = '0;
      periph_evt = '0;
      cyc(5);
      chk($sformatf("R3/R4 req vector %0d", k), 16'(irq_req), 16'(TAB[k].req));
      chk($sformatf("R8 wake vector %0d", k), 16'(wake), 16'(TAB[k].wk));
      rd(3'd0, d);
      chk($sformatf("R1 core flags vector %0d", k), 16'(d[2:0]), 16'(TAB[k].cev));
      rd(3'd1, d);
      chk($sformatf("R1 pflag lo vector %0d", k), 16'(d), 16'(TAB[k].pev[7:0]));
      rd(3'd2, d);
      chk($sformatf("R1 pflag hi vector %0d", k), 16'(d), 16'(TAB[k].pev[13:8]));
    end

    // R11 latency
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd0, 8'h88);
    core_evt = 3'b001;
    @(negedge clk); core_evt = '0;
    rd(3'd0, d); chk("R11 flag after edge 1", 16'(d[0]), 16'h0);
    @(negedge clk);
    rd(3'd0, d); chk("R11 flag after edge 2", 16'(d[0]), 16'h0);
    @(negedge clk);
    rd(3'd0, d); chk("R11 flag after edge 3", 16'(d[0]), 16'h1);
    chk("R11 req after edge 3", 16'(irq_req), 16'h0);
    @(negedge clk);
    chk("R11 req after edge 4", 16'(irq_req), 16'h1);

    // R1 held level sets once
    wr(3'd0, 8'h00);
    core_evt = 3'b010;
    cyc(5);
    wr(3'd0, 8'h00);
    cyc(5);
    rd(3'd0, d); chk("R1 held level no re-set", 16'(d[1]), 16'h0);
    core_evt = '0;
    cyc(3);

    // R2 same-cycle event beats clear, plain clear works
    core_evt = 3'b100;
    @(negedge clk); core_evt = '0;
    cyc(4);
    rd(3'd0, d); chk("R2 flag set before race", 16'(d[2]), 16'h1);
    core_evt = 3'b100;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h00;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(3'd0, d); chk("R2 event wins over clear", 16'(d[2]), 16'h1);
    core_evt = '0;
    cyc(3);
    wr(3'd0, 8'h00);
    rd(3'd0, d); chk("R2 write clears flag", 16'(d[2]), 16'h0);

    // R5 R6 R7 handshake
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd3, 8'h01); wr(3'd4, 8'h00);
    periph_evt = 14'h0001;
    @(negedge clk); periph_evt = '0;
    cyc(5);
    chk("R5 no req without enables", 16'(irq_req), 16'h0);
    wr(3'd0, 8'h40);
    cyc(3);
    chk("R5 held pending with gie clear", 16'(irq_req), 16'h0);
    chk("R8 wake with gie clear", 16'(wake), 16'h1);
    wr(3'd0, 8'hC0);
    @(negedge clk);
    chk("R5 pending raises req", 16'(irq_req), 16'h1);
    irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R6 req drops on ack", 16'(irq_req), 16'h0);
    rd(3'd0, d); chk("R6 gie cleared on ack", 16'(d[7]), 16'h0);
    cyc(2);
    chk("R6 req stays low", 16'(irq_req), 16'h0);
    irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
    rd(3'd0, d); chk("R7 gie set on return", 16'(d[7]), 16'h1);
    @(negedge clk);
    chk("R7 leftover flag re-requests", 16'(irq_req), 16'h1);
    wr(3'd1, 8'h00);
    irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
    cyc(2);
    chk("R7 no req after clean return", 16'(irq_req), 16'h0);
    chk("R10 vector after service", 16'(vec_addr), 16'h0004);

    // R12 enable readback and unused bits
    wr(3'd3, 8'hA5);
    rd(3'd3, d); chk("R12 enable lo readback", 16'(d), 16'h00A5);
    wr(3'd4, 8'hFF);
    rd(3'd4, d); chk("R12 enable hi unused bits", 16'(d), 16'h003F);
    rd(3'd5, d); chk("R12 unmapped address", 16'(d), 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule